// File: doc/BRIEF.md
# Burst Window Register Redirector

This block sits in front of a bank of 16-bit peripheral registers and gives a DMA engine one fixed window address through which it can walk a run of consecutive registers. A control register holds a base register number and a burst length. Each read or write at the window address is steered to the target register numbered base plus a running index. The index then steps forward, and it returns to zero once the programmed number of transfers has been made, so the next burst starts again at the base.

The bus is word addressed. Word addresses 0 to NUM_REGS-1 reach the target registers directly. Word address 18 (byte offset 0x48) is the control register and word address 19 (byte offset 0x4C) is the window. Read data is combinational and is valid in the same cycle as the read strobe; writes take effect at the next rising clock edge. The whole target bank is also presented as a flat output vector for the logic that uses those registers.

Top module: `burst_win_top`

## Requirements
- R1: After reset the control register, the running index and every target register are zero, so reads of the control word, of a target and of the window all return 0.
- R2: The control register at word address 18 holds the burst length in bits 12:8 and the base register number in bits 4:0. A burst makes length+1 transfers, and both fields read back where they were written.
- R3: Control bits 15:13 and 7:5 always read as zero, and writing ones to them has no effect.
- R4: A read at word address 19 returns, in the same cycle as the read strobe, the target register numbered base + index.
- R5: Each access at the window (a read, a write or both) moves the index up by one. When the index is equal to or above the length field, the access returns it to 0. Successive window accesses therefore visit base, base+1, …, base+length in ascending order and then start over.
- R6: Any write to the control register sets the index to 0.
- R7: A redirected target number of NUM_REGS or more reads as zero and ignores writes, and the index still advances.
- R8: Reads and writes at word addresses 0 to NUM_REGS-1 reach that register directly and leave the index unchanged.
- R9: A write at the window stores the write data into the redirected target at the next clock edge. Reads and writes through the window can be interleaved, and each one uses and advances the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when no read |
| regs_flat | output | NUM_REGS*16 | All target registers, register k in bits k*16+15 : k*16 |

## Verification
The bench keeps the default of eighteen target registers, so bank indices 0 to 17 are real while the control and window words sit just past them. With a 5-bit base and a 5-bit length, the redirected number can run well past register 17. That makes the zero-read and ignored-write region easy to reach from a length-31 burst, and also from a base of 16 or 17. It also means a burst that wraps inside the bank can be checked in the same run.

// File: rtl/burst_win_pkg.sv
package burst_win_pkg;

    localparam int DATA_W = 16;
    localparam int FLD_W  = 5;

    // Fixed word addresses of the control word and the window
    localparam int CTL_WORD = 18;
    localparam int WIN_WORD = 19;

    typedef struct packed {
        logic [FLD_W-1:0] len;
        logic [FLD_W-1:0] base;
        logic [FLD_W-1:0] idx;
    } seq_state_t;

endpackage

// File: rtl/burst_win_seq.sv
module burst_win_seq
    import burst_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [FLD_W-1:0] len_in,
    input  logic [FLD_W-1:0] base_in,
    input  logic             win_acc,
    output logic [FLD_W-1:0] len,
    output logic [FLD_W-1:0] base,
    output logic [FLD_W-1:0] idx
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.len  = len_in;
            st_d.base = base_in;
            st_d.idx  = '0;
        end else if (win_acc) begin
            if (st_q.idx >= st_q.len) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len  = st_q.len;
    assign base = st_q.base;
    assign idx  = st_q.idx;

endmodule

// File: rtl/burst_win_bank.sv
module burst_win_bank
    import burst_win_pkg::*;
#(
    parameter int NUM_REGS = 18,
    parameter int IDX_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_idx == MY_IDX)) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end

        assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    // Numbers outside the bank match no register and read as zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/burst_win_top.sv
module burst_win_top
    import burst_win_pkg::*;
#(
    parameter int NUM_REGS = 18,
    parameter int ADDR_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_WORD);
    localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(WIN_WORD);
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

    logic [FLD_W-1:0]  burst_len;
    logic [FLD_W-1:0]  burst_base;
    logic [FLD_W-1:0]  burst_idx;
    logic [ADDR_W-1:0] tgt_num;
    logic              ctl_hit;
    logic              win_hit;
    logic              dir_hit;
    logic              win_acc;
    logic [ADDR_W-1:0] bank_idx;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] ctl_view;

    assign ctl_hit = (bus_addr == CTL_A);
    assign win_hit = (bus_addr == WIN_A);
    assign dir_hit = (bus_addr < NREG_A);
    assign win_acc = win_hit && (bus_wr || bus_rd);

    assign tgt_num  = ADDR_W'(burst_base) + ADDR_W'(burst_idx);
    assign bank_idx = win_hit ? tgt_num : bus_addr;

    burst_win_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_hit && bus_wr),
        .len_in  (bus_wdata[12:8]),
        .base_in (bus_wdata[4:0]),
        .win_acc (win_acc),
        .len     (burst_len),
        .base    (burst_base),
        .idx     (burst_idx)
    );

    burst_win_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && (dir_hit || win_hit)),
        .wr_idx    (bank_idx),
        .wr_data   (bus_wdata),
        .rd_idx    (bank_idx),
        .rd_data   (bank_rd),
        .regs_flat (regs_flat)
    );

    assign ctl_view = {3'b000, burst_len, 3'b000, burst_base};

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (ctl_hit) begin
                bus_rdata = ctl_view;
            end else if (dir_hit || win_hit) begin
                bus_rdata = bank_rd;
            end
        end
    end

endmodule

// File: rtl/burst_win_chk.sv
module burst_win_chk
    import burst_win_pkg::*;
#(
    parameter int NUM_REGS = 18,
    parameter int ADDR_W   = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_REGS*DATA_W-1:0] regs_flat,
    input logic [FLD_W-1:0]           idx,
    input logic [FLD_W-1:0]           len,
    input logic [FLD_W-1:0]           base
);

    localparam int SW = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_WORD);
    localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(WIN_WORD);
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

    logic [ADDR_W-1:0] tgt;
    logic              win_acc;
    logic              ctl_wr;
    logic              pend_q;
    logic [SW-1:0]     pend_idx_q;
    logic [DATA_W-1:0] pend_data_q;
    logic [DATA_W-1:0] regs_a [NUM_REGS];

    assign tgt     = ADDR_W'(base) + ADDR_W'(idx);
    assign win_acc = (bus_addr == WIN_A) && (bus_wr || bus_rd);
    assign ctl_wr  = (bus_addr == CTL_A) && bus_wr;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_un
        assign regs_a[g] = regs_flat[g*DATA_W +: DATA_W];
    end

    // Remember an in-range window write for the check one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else begin
            pend_q      <= (bus_addr == WIN_A) && bus_wr && (tgt < NREG_A);
            pend_idx_q  <= SW'(tgt);
            pend_data_q <= bus_wdata;
        end
    end

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CTL_A) |-> (bus_rdata[15:13] == 3'b000 && bus_rdata[7:5] == 3'b000));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !ctl_wr && idx < len) |=> (idx == $past(idx) + 1'b1));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !ctl_wr && idx >= len) |=> (idx == '0));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (idx == '0));

    a_r7_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == WIN_A && tgt >= NREG_A) |-> (bus_rdata == '0));

    a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_acc && !ctl_wr) |=> $stable(idx));

    a_r9_win_write: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (regs_a[pend_idx_q] == pend_data_q));

endmodule

bind burst_win_top burst_win_chk #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .regs_flat (regs_flat),
    .idx       (burst_idx),
    .len       (burst_len),
    .base      (burst_base)
);

// File: tb/sim_burst_win_top.sv
`timescale 1ns/1ps
module sim_burst_win_top;

    localparam int NREG = 18;
    localparam int AW   = 6;
    localparam logic [AW-1:0] CTL = 6'd18;
    localparam logic [AW-1:0] WIN = 6'd19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic [NREG*16-1:0] regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_win_top #(.NUM_REGS(NREG), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .regs_flat (regs)
    );

    // Vector: {base[4:0], len[4:0], count[5:0]}
    localparam logic [15:0] VEC [4] = '{
        {5'd0,  5'd6,  6'd7},
        {5'd3,  5'd2,  6'd8},
        {5'd0,  5'd31, 6'd33},
        {5'd16, 5'd3,  6'd9}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    function automatic logic [15:0] fill(input int t);
        return (t < NREG) ? 16'(16'hA000 + t) : 16'h0000;
    endfunction

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(CTL, v);    check("R1 ctl", v, 16'h0000);
        bus_read(6'd5, v);   check("R1 target", v, 16'h0000);
        bus_read(WIN, v);    check("R1 window", v, 16'h0000);

        // R3: reserved bits, R2 field readback
        bus_write(CTL, 16'hFFFF);
        bus_read(CTL, v);    check("R3 reserved", v, 16'h1F1F);
        bus_write(CTL, 16'h0A05);
        bus_read(CTL, v);    check("R2 fields", v, 16'h0A05);

        // Prefill targets directly (R8)
        for (int t = 0; t < NREG; t++) bus_write(AW'(t), fill(t));
        bus_read(6'd9, v);   check("R8 direct", v, fill(9));

        // R4/R5/R7: table of bursts
        for (int n = 0; n < 4; n++) begin
            int b = int'(VEC[n][15:11]);
            int l = int'(VEC[n][10:6]);
            int c = int'(VEC[n][5:0]);
            bus_write(CTL, 16'((l << 8) | b));
            for (int k = 0; k < c; k++) begin
                bus_read(WIN, v);
                check("R5 burst sequence", v, fill(b + (k % (l + 1))));
            end
        end

        // R8: direct access mid-burst does not move index
        bus_write(CTL, 16'h0304);
        bus_read(WIN, v);    check("R4 window", v, fill(4));
        bus_read(6'd10, v);  check("R8 direct read", v, fill(10));
        bus_write(6'd10, 16'h1234);
        bus_read(WIN, v);    check("R8 index held", v, fill(5));
        bus_read(WIN, v);    check("R5 next", v, fill(6));

        // R6: control write clears index
        bus_write(CTL, 16'h0304);
        bus_read(WIN, v);    check("R6 clear", v, fill(4));

        // R9: mixed reads and writes
        bus_write(CTL, 16'h0202);
        bus_write(WIN, 16'h1111);
        bus_read(WIN, v);    check("R9 mixed read", v, fill(3));
        bus_write(WIN, 16'h3333);
        bus_read(WIN, v);    check("R9 wrap after write", v, 16'h1111);
        bus_read(6'd4, v);   check("R9 window write", v, 16'h3333);

        // R7: out-of-range write ignored, index still advances
        bus_write(CTL, 16'h0111);
        bus_write(WIN, 16'hBEEF);
        bus_write(WIN, 16'hDEAD);
        bus_read(WIN, v);    check("R7 advance past oob", v, 16'hBEEF);
        bus_read(6'd0, v);   check("R7 no alias", v, fill(0));
        check("R7 last reg port", regs[17*16 +: 16], 16'hBEEF);
        check("R7 reg16 untouched", regs[16*16 +: 16], fill(16));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule